// File: doc/BRIEF.md
# Shadow Register Integrity Monitor

This block guards a small bank of pin-mapping control registers against silent corruption. It keeps two copies of every register: a live copy, which drives the pin routing, and a shadow copy, which only the monitor holds. A bus write is the only legitimate way to change a register, and it loads both copies on the same clock edge. A comparator checks every live/shadow pair on every clock, whether or not the bank is being accessed. Any disagreement means a register changed without a write, for example a bit upset by an electrical disturbance.

When a disagreement appears, the block issues a one-cycle reset request to the device reset generator. On the same edge it reloads both copies with their default values and sets a sticky mismatch flag. The flag is visible at bit 9 of a 16-bit reset status word. Only a power-on or brown-out reset (the synchronous `rst_n`) or an explicit status write clears it. A test port can flip one bit of one live register without touching its shadow, so the detection path can be exercised on silicon.

Top module: `shadow_integrity_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register k takes its default value (k*37+17, truncated to REG_W bits). After that edge `cm_flag` is 0, `status_word` is 0 and `rst_req` is 0.
- R2: A write with `wr_en` high and an in-range `wr_addr` loads `wr_data` into the live and the shadow copy on the same edge. From the next cycle `rd_data` returns the written value, and the write never raises `rst_req`.
- R3: The pairs are compared on every cycle with no access needed. A live bit flipped at edge k raises `rst_req` during the cycle that follows edge k+1.
- R4: `rst_req` is high for exactly one cycle per mismatch event.
- R5: On the edge that raises `rst_req`, both copies of every register are reloaded with their defaults. While `rst_req` is high, all pairs agree and reads return defaults.
- R6: A mismatch sets `cm_flag` on the same edge that raises `rst_req`. The flag then stays set. `status_word` carries the flag at bit 9 and 0 in every other bit.
- R7: A status write (`stat_wr_en` high) loads bit 9 of `stat_wr_data` into the flag, so software can either clear it or set it. If a mismatch occurs on the same edge, the flag is set regardless of the written value.
- R8: `rst_n` low clears a set `cm_flag`.
- R9: An injection aimed at the register being written on the same edge is still applied on top of the written data, and it is detected as in R3.
- R10: A write to an address at or above NUM_REGS changes nothing. A read at such an address returns 0.
- R11: An injection at an address at or above NUM_REGS has no effect: no `rst_req`, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on / brown-out reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | REG_W | Live value of the addressed register (combinational) |
| stat_wr_en | input | 1 | Status word write strobe |
| stat_wr_data | input | 16 | Status write data; bit 9 goes to the mismatch flag |
| status_word | output | 16 | Reset status word; bit 9 is the mismatch flag |
| inj_en | input | 1 | Test-only fault-injection strobe |
| inj_addr | input | ADDR_W | Register whose live copy gets one bit flipped |
| inj_bit | input | BIT_W | Bit position to flip |
| rst_req | output | 1 | Single-cycle configuration-mismatch reset request |
| cm_flag | output | 1 | Sticky mismatch flag |

## Verification
The main function is tried with four kinds of stimulus.

- Plain writes alone should never trigger a request; this separates a legitimate change from a corruption.
- A bare injection on an idle bank shows that detection is continuous and does not depend on an access. The bench then confirms the exact cycle of the request and that both copies reload to their defaults.
- An injection landing on a register that is being written on the same edge shows that a write cannot hide a flip.
- An injection or write to an out-of-range address should do nothing. This separates address decoding from the comparison itself.

Status writes alone, and status writes racing a mismatch, confirm that the flag is sticky and that a mismatch wins over a software clear.

// File: rtl/shadow_mon_pkg.sv
// Package: constants and the default-value rule shared by the monitor modules.
// Assumes the status word is 16 bits with the mismatch flag at bit 9.
package shadow_mon_pkg;

    localparam int STAT_W = 16;
    localparam int CM_BIT = 9;

    // Default contents of register idx before truncation to the register width.
    function automatic logic [31:0] reg_default(input int idx);
        return 32'(idx * 37 + 17);
    endfunction

endpackage

// File: rtl/cfg_reg_bank.sv
// Module: one bank of NUM_REGS registers (used both for the live and the shadow copy).
// Write, optional one-bit injection and a reload to defaults.
// Assumes the reload has priority over writes and injections.
module cfg_reg_bank #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 3,
    parameter int BIT_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reload,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      inj_en,
    input  logic [ADDR_W-1:0]         inj_addr,
    input  logic [BIT_W-1:0]          inj_bit,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    import shadow_mon_pkg::*;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] DFLT = REG_W'(reg_default(i));
        logic [REG_W-1:0] q;
        logic [REG_W-1:0] flip;
        logic             hit_wr;

        // Decode the write and build the injection mask for this register.
        always_comb begin
            hit_wr = wr_en && (wr_addr == ADDR_W'(i));
            flip   = (inj_en && (inj_addr == ADDR_W'(i))) ? (REG_W'(1) << inj_bit) : '0;
        end

        // Register update: reset/reload, then write, then injection on top.
        always_ff @(posedge clk) begin
            if (!rst_n || reload) begin
                q <= DFLT;
            end else if (hit_wr) begin
                q <= wr_data ^ flip;
            end else begin
                q <= q ^ flip;
            end
        end

        assign regs_flat[i*REG_W +: REG_W] = q;

        AST_RELOAD_LOADS_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
            reload |=> (q == DFLT)) else $error("reload did not restore default"); // R5
    end

endmodule

// File: rtl/pair_compare.sv
// Module: compares each live register with its shadow on every cycle.
// Assumes both inputs use the same flat packing.
module pair_compare #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8
) (
    input  logic [NUM_REGS*REG_W-1:0] live_flat,
    input  logic [NUM_REGS*REG_W-1:0] shadow_flat,
    output logic [NUM_REGS-1:0]       diff_vec,
    output logic                      any_diff
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
        // Per-pair disagreement.
        assign diff_vec[i] = (live_flat[i*REG_W +: REG_W] != shadow_flat[i*REG_W +: REG_W]);
    end

    // Any pair disagreeing.
    assign any_diff = |diff_vec;

endmodule

// File: rtl/mismatch_ctrl.sv
// Module: turns a disagreement into a one-cycle reset request and a sticky flag.
// Assumes the banks reload on any_diff, so a mismatch lasts one cycle.
module mismatch_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic any_diff,
    input  logic stat_wr_en,
    input  logic stat_wr_cm,
    output logic rst_req,
    output logic cm_flag
);
    // Register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= any_diff;
        end
    end

    // Sticky flag: a mismatch sets it, a status write loads it, otherwise it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_flag <= 1'b0;
        end else if (any_diff) begin
            cm_flag <= 1'b1;
        end else if (stat_wr_en) begin
            cm_flag <= stat_wr_cm;
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req) else $error("reset request longer than one cycle"); // R4
    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cm_flag) else $error("flag not set with request"); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_flag && !stat_wr_en) |=> cm_flag) else $error("flag dropped without write"); // R6
    AST_MISMATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && any_diff && stat_wr_en && !stat_wr_cm) |=> cm_flag) else $error("clear beat mismatch"); // R7

endmodule

// File: rtl/shadow_integrity_mon.sv
// Module: top of the integrity monitor. Holds a live bank and a shadow bank,
// compares them every cycle, requests a reset and reloads defaults on mismatch.
// Assumes rst_n is synchronous and is the power-on / brown-out reset.
module shadow_integrity_mon #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    parameter int BIT_W    = (REG_W > 1) ? $clog2(REG_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              stat_wr_en,
    input  logic [15:0]       stat_wr_data,
    output logic [15:0]       status_word,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [BIT_W-1:0]  inj_bit,
    output logic              rst_req,
    output logic              cm_flag
);
    import shadow_mon_pkg::*;

    localparam int FLAT_W = NUM_REGS * REG_W;

    logic [FLAT_W-1:0]   live_flat;
    logic [FLAT_W-1:0]   shadow_flat;
    logic [NUM_REGS-1:0] diff_vec;
    logic                any_diff;
    logic                unused_stat;

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_live (
        .clk(clk), .rst_n(rst_n), .reload(any_diff),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
        .regs_flat(live_flat)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .reload(any_diff),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_en(1'b0), .inj_addr('0), .inj_bit('0),
        .regs_flat(shadow_flat)
    );

    pair_compare #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_cmp (
        .live_flat(live_flat), .shadow_flat(shadow_flat),
        .diff_vec(diff_vec), .any_diff(any_diff)
    );

    mismatch_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .any_diff(any_diff),
        .stat_wr_en(stat_wr_en), .stat_wr_cm(stat_wr_data[CM_BIT]),
        .rst_req(rst_req), .cm_flag(cm_flag)
    );

    // Read mux over the live bank; out-of-range addresses read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = live_flat[i*REG_W +: REG_W];
            end
        end
    end

    // Status word: only the mismatch flag is carried.
    assign status_word = STAT_W'(cm_flag) << CM_BIT;
    assign unused_stat = ^(stat_wr_data & ~(STAT_W'(1) << CM_BIT));

    AST_RELOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (live_flat == shadow_flat)) else $error("pairs differ during request"); // R5
    AST_WRITE_NO_FALSE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !inj_en && !any_diff) |=> !any_diff) else $error("write caused mismatch"); // R2
    AST_INJECT_DETECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && inj_en && (int'(inj_addr) < NUM_REGS) && !any_diff) |=> any_diff) else $error("flip missed"); // R3

endmodule

// File: tb/shadow_integrity_mon_bench.sv
module shadow_integrity_mon_bench;
    localparam int NR = 6;
    localparam int RW = 8;
    localparam int AW = 3;
    localparam int BW = 3;
    localparam time CLK_P = 8ns;

    typedef struct {
        int          kind;   // 0 rd_data, 1 rst_req, 2 cm_flag, 3 status_word
        logic [15:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic stat_wr_en = 1'b0;
    logic [15:0] stat_wr_data = '0;
    logic [15:0] status_word;
    logic inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [BW-1:0] inj_bit = '0;
    logic rst_req;
    logic cm_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    item_t q[$];

    always #(CLK_P/2) clk = ~clk;

    shadow_integrity_mon u_shadow_integrity_mon (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .stat_wr_en(stat_wr_en),
        .stat_wr_data(stat_wr_data), .status_word(status_word), .inj_en(inj_en),
        .inj_addr(inj_addr), .inj_bit(inj_bit), .rst_req(rst_req), .cm_flag(cm_flag)
    );

    function automatic logic [RW-1:0] dflt(input int k);
        return RW'(k * 37 + 17);
    endfunction

    // Monitor: pop every pending expectation at the falling edge and compare.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = 16'(rd_data);
                1: act = 16'(rst_req);
                2: act = 16'(cm_flag);
                default: act = status_word;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input int kind, input logic [15:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic expect_read(input int a, input logic [RW-1:0] v, input string req);
        rd_addr = AW'(a);
        expect_item(0, 16'(v), req);
        step();
    endtask

    task automatic do_write(input int a, input logic [RW-1:0] v);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_stat(input logic [15:0] v);
        stat_wr_en = 1'b1; stat_wr_data = v;
        step();
        stat_wr_en = 1'b0;
    endtask

    // Driver: stimulus and expected values.
    initial begin
        step(); step();
        rst_n = 1'b1;
        // R1 reset state
        expect_item(1, 16'h0, "R1");
        expect_item(2, 16'h0, "R1");
        expect_item(3, 16'h0, "R1");
        for (int k = 0; k < NR; k++) expect_read(k, dflt(k), "R1");

        // R2 legitimate writes, no request
        do_write(2, 8'hA5);
        expect_item(1, 16'h0, "R2");
        do_write(5, 8'h3C);
        expect_item(1, 16'h0, "R2");
        expect_read(2, 8'hA5, "R2");
        expect_read(5, 8'h3C, "R2");
        expect_item(2, 16'h0, "R2");

        // R10 out-of-range write and read
        do_write(7, 8'hFF);
        expect_item(1, 16'h0, "R10");
        expect_read(7, 8'h00, "R10");
        expect_read(6, 8'h00, "R10");
        expect_read(2, 8'hA5, "R10");

        // R3 bare injection on an idle bank
        step(); step(); step();
        inj_en = 1'b1; inj_addr = 3'd2; inj_bit = 3'd4;
        step();                       // edge k: flip applied
        inj_en = 1'b0;
        expect_item(1, 16'h0, "R3");  // not yet requested
        step();                       // edge k+1
        expect_item(1, 16'h1, "R3");
        expect_item(2, 16'h1, "R6");
        expect_item(3, 16'h0200, "R6");
        expect_read(2, dflt(2), "R5"); // read during the request cycle
        expect_item(1, 16'h0, "R4");
        expect_read(5, dflt(5), "R5");
        step(); step();
        expect_item(2, 16'h1, "R6");

        // R7 software clear and set
        do_stat(16'hFDFF);
        expect_item(2, 16'h0, "R7");
        expect_item(3, 16'h0, "R7");
        do_stat(16'h0200);
        expect_item(2, 16'h1, "R7");
        do_stat(16'h0000);
        expect_item(2, 16'h0, "R7");

        // R9 injection on a register written in the same cycle
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h77;
        inj_en = 1'b1; inj_addr = 3'd1; inj_bit = 3'd0;
        step();
        wr_en = 1'b0; inj_en = 1'b0;
        expect_item(1, 16'h0, "R9");
        step();
        expect_item(1, 16'h1, "R9");
        expect_read(1, dflt(1), "R9");
        expect_item(1, 16'h0, "R4");

        // R7 mismatch beats a simultaneous software clear
        do_stat(16'h0000);
        inj_en = 1'b1; inj_addr = 3'd0; inj_bit = 3'd7;
        step();
        inj_en = 1'b0;
        stat_wr_en = 1'b1; stat_wr_data = 16'h0000;
        step();
        stat_wr_en = 1'b0;
        expect_item(1, 16'h1, "R7");
        expect_item(2, 16'h1, "R7");

        // R11 out-of-range injection ignored
        do_write(3, 8'h5A);
        inj_en = 1'b1; inj_addr = 3'd6; inj_bit = 3'd1;
        step();
        inj_en = 1'b0;
        step();
        expect_item(1, 16'h0, "R11");
        expect_read(3, 8'h5A, "R11");
        expect_item(1, 16'h0, "R11");
        expect_read(0, dflt(0), "R11");

        // R8 power-on reset clears the flag
        expect_item(2, 16'h1, "R8");
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        expect_item(2, 16'h0, "R8");
        expect_read(3, dflt(3), "R1");

        step(); step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule